// File: doc/BRIEF.md
# Delay to element-count encoder

This block turns a requested pin delay into the settings of a two-stage delay line: a count of coarse elements and a count of fine elements. It then packs the two counts into one 32-bit configuration word. A request has two parts. One is a delay on a fixed scale, where a coarse element is 920 ps and a fine element is one sixth of a tenth-step. The other is a delay on a calibrated scale, which uses a coarse and a fine per-element parameter measured elsewhere. The block converts each part, adds the results and hands back one word.

A client holds the request and the two parameters steady and pulses `start`. A single shared shift-subtract divider carries out every quotient and remainder in a fixed order under a small state machine. When the fine total grows past 22, the block folds the counts back into a total delay and splits that total again using only the calibrated scale. A one-cycle `done` returns the word, a per-field overflow flag for each count and an error flag.

Top module: `dly_elem_encoder`

## Requirements
- R1: The request word carries the calibrated-scale delay (ps) in bits 15:0 and the fixed-scale delay (ps) in bits 31:16.
- R2: Fixed-scale part: coarse = delay / 920 and fine term = ((delay mod 920) * 10) / 60. Every division truncates.
- R3: Calibrated part: coarse = delay / coarse_param and fine term = ((delay mod coarse_param) * 10) / fine_param.
- R4: Coarse count = sum of the two coarse results. Fine count = (sum of the two fine terms) / 10.
- R5: Renormalisation happens only when the fine count is 23 or more; a fine count of exactly 22 is kept as is. It forms total = coarse*coarse_param + fine*fine_param, truncated to 32 bits. It then recomputes coarse = total / coarse_param and fine = (total mod coarse_param) / fine_param.
- R6: Output word layout: bits 17:12 hold 0x29, bit 10 is 1, bits 9:5 hold the coarse count and bits 4:0 hold the fine count. Bits 31:18 and bit 11 are 0.
- R7: A count above 31 keeps only its low 5 bits in the word and raises its own flag: `ovf_coarse` for the coarse count, `ovf_fine` for the fine count.
- R8: If either parameter is zero when `start` is taken, no division runs. On the next cycle `done` and `err` are 1, `cfg_word` is 0, both overflow flags are 0 and `busy` stays 0.
- R9: `done` is a single-cycle pulse. `busy` is 1 from the cycle after an accepted `start` until the cycle in which `done` rises.
- R10: A `start` while `busy` is 1 is ignored. The running result is unchanged and no extra `done` follows.
- R11: After reset, `busy`, `done`, `err`, both overflow flags and `cfg_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse; taken only when idle |
| req_word | input | 32 | Fixed-scale delay [31:16], calibrated delay [15:0] |
| coarse_param | input | 32 | Calibrated ps per coarse element |
| fine_param | input | 32 | Calibrated fine scale (tenths) |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | With done: a parameter was zero |
| cfg_word | output | 32 | Packed configuration word |
| ovf_coarse | output | 1 | Coarse count exceeded its field |
| ovf_fine | output | 1 | Fine count exceeded its field |

## Verification
The error path has a fixed latency. `done` and `err` are due in the first cycle after the edge that samples `start`, so the bench reads them at the very next falling edge. A normal conversion runs five or seven divisions of about 34 cycles each. For that path the bench polls `done` at falling edges with a bound and reads word and flags in the cycle `done` is seen. It then checks that `done` has dropped one cycle later. `busy` is checked at the first falling edge after `start`, and for R10 the bench counts `done` pulses over a long window.

// File: rtl/dly_enc_pkg.sv
package dly_enc_pkg;

  localparam int unsigned WORD_W       = 32;
  localparam int unsigned FIELD_W      = 5;
  localparam int unsigned FINE_LSB     = 0;
  localparam int unsigned COARSE_LSB   = FINE_LSB + FIELD_W;
  localparam int unsigned HOLD_BIT     = 10;
  localparam int unsigned SIG_LSB      = 12;
  localparam int unsigned SIG_W        = 6;
  localparam logic [SIG_W-1:0] SIG_VAL = 6'h29;

  localparam int unsigned FIX_COARSE_PS = 920;
  localparam int unsigned FIX_FINE_DIV  = 60;
  localparam int unsigned TENTHS        = 10;
  localparam int unsigned FINE_LIMIT    = 22;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GC,
    ST_GF,
    ST_AC,
    ST_AF,
    ST_SUM,
    ST_RC,
    ST_RF,
    ST_PACK
  } enc_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic              ovf_c;
    logic              ovf_f;
  } pack_res_t;

endpackage

// File: rtl/dly_enc_divider.sv
module dly_enc_divider #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          fin,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem
);

  localparam int unsigned CW = $clog2(DW + 1);

  logic [DW-1:0] q_r;
  logic [DW-1:0] r_r;
  logic [DW-1:0] den_r;
  logic [CW-1:0] cnt;
  logic          fin_r;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          fits;

  always_comb begin
    trial = {r_r, q_r[DW-1]};
    diff  = trial - {1'b0, den_r};
    fits  = (trial >= {1'b0, den_r});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      r_r   <= '0;
      den_r <= '0;
      cnt   <= '0;
      fin_r <= 1'b0;
    end else if (go) begin
      q_r   <= num;
      r_r   <= '0;
      den_r <= den;
      cnt   <= CW'(DW);
      fin_r <= 1'b0;
    end else if (cnt != '0) begin
      if (fits) begin
        r_r <= diff[DW-1:0];
        q_r <= {q_r[DW-2:0], 1'b1};
      end else begin
        r_r <= trial[DW-1:0];
        q_r <= {q_r[DW-2:0], 1'b0};
      end
      cnt   <= cnt - 1'b1;
      fin_r <= (cnt == CW'(1));
    end else begin
      fin_r <= 1'b0;
    end
  end

  assign fin = fin_r;
  assign quo = q_r;
  assign rem = r_r;

endmodule

// File: rtl/dly_enc_pack.sv
module dly_enc_pack
  import dly_enc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0]     c_cnt,
  input  logic [DW-1:0]     f_cnt,
  output logic [WORD_W-1:0] word,
  output logic              ovf_c,
  output logic              ovf_f
);

  localparam logic [DW-1:0] FIELD_MAX = DW'((1 << FIELD_W) - 1);

  function automatic pack_res_t build_word(input logic [DW-1:0] c, input logic [DW-1:0] f);
    pack_res_t res;
    res.word = '0;
    res.word[SIG_LSB +: SIG_W]       = SIG_VAL;
    res.word[HOLD_BIT]               = 1'b1;
    res.word[COARSE_LSB +: FIELD_W]  = c[FIELD_W-1:0];
    res.word[FINE_LSB +: FIELD_W]    = f[FIELD_W-1:0];
    res.ovf_c = (c > FIELD_MAX);
    res.ovf_f = (f > FIELD_MAX);
    return res;
  endfunction

  pack_res_t res;

  always_comb begin
    res   = build_word(c_cnt, f_cnt);
    word  = res.word;
    ovf_c = res.ovf_c;
    ovf_f = res.ovf_f;
  end

endmodule

// File: rtl/dly_enc_ctrl.sv
module dly_enc_ctrl
  import dly_enc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] req_word,
  input  logic [DW-1:0]     coarse_param,
  input  logic [DW-1:0]     fine_param,
  input  logic              div_fin,
  input  logic [DW-1:0]     div_q,
  input  logic [DW-1:0]     div_r,
  output logic              div_go,
  output logic [DW-1:0]     div_num,
  output logic [DW-1:0]     div_den,
  output logic [DW-1:0]     c_tot,
  output logic [DW-1:0]     f_tot,
  input  logic [WORD_W-1:0] pack_word,
  input  logic              pack_ovf_c,
  input  logic              pack_ovf_f,
  output logic              renorm_take,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] cfg_word,
  output logic              ovf_coarse,
  output logic              ovf_fine
);

  localparam int unsigned HALF = WORD_W / 2;
  localparam logic [DW-1:0] K_TEN   = DW'(TENTHS);
  localparam logic [DW-1:0] K_FIXC  = DW'(FIX_COARSE_PS);
  localparam logic [DW-1:0] K_FIXF  = DW'(FIX_FINE_DIV);
  localparam logic [DW-1:0] K_LIMIT = DW'(FINE_LIMIT);

  enc_state_e    state;
  logic [DW-1:0] cp_r;
  logic [DW-1:0] fp_r;
  logic [DW-1:0] cal_r;
  logic [DW-1:0] fix_fine_r;
  logic [DW-1:0] fix_coarse_r;
  logic [DW-1:0] total;
  logic          accept;
  logic          bad_param;

  always_comb begin
    accept      = start && (state == ST_IDLE);
    bad_param   = (coarse_param == '0) || (fine_param == '0);
    total       = c_tot * cp_r + div_q * fp_r;
    renorm_take = (state == ST_SUM) && div_fin && (div_q > K_LIMIT);
    busy        = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cp_r         <= '0;
      fp_r         <= '0;
      cal_r        <= '0;
      fix_fine_r   <= '0;
      fix_coarse_r <= '0;
      c_tot        <= '0;
      f_tot        <= '0;
      div_go       <= 1'b0;
      div_num      <= '0;
      div_den      <= '0;
      done         <= 1'b0;
      err          <= 1'b0;
      cfg_word     <= '0;
      ovf_coarse   <= 1'b0;
      ovf_fine     <= 1'b0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            if (bad_param) begin
              done       <= 1'b1;
              err        <= 1'b1;
              cfg_word   <= '0;
              ovf_coarse <= 1'b0;
              ovf_fine   <= 1'b0;
            end else begin
              cp_r    <= coarse_param;
              fp_r    <= fine_param;
              cal_r   <= DW'(req_word[HALF-1:0]);
              div_num <= DW'(req_word[WORD_W-1:HALF]);
              div_den <= K_FIXC;
              div_go  <= 1'b1;
              state   <= ST_GC;
            end
          end
        end
        ST_GC: begin
          if (div_fin) begin
            fix_coarse_r <= div_q;
            div_num      <= div_r * K_TEN;
            div_den      <= K_FIXF;
            div_go       <= 1'b1;
            state        <= ST_GF;
          end
        end
        ST_GF: begin
          if (div_fin) begin
            fix_fine_r <= div_q;
            div_num    <= cal_r;
            div_den    <= cp_r;
            div_go     <= 1'b1;
            state      <= ST_AC;
          end
        end
        ST_AC: begin
          if (div_fin) begin
            c_tot   <= fix_coarse_r + div_q;
            div_num <= div_r * K_TEN;
            div_den <= fp_r;
            div_go  <= 1'b1;
            state   <= ST_AF;
          end
        end
        ST_AF: begin
          if (div_fin) begin
            div_num <= fix_fine_r + div_q;
            div_den <= K_TEN;
            div_go  <= 1'b1;
            state   <= ST_SUM;
          end
        end
        ST_SUM: begin
          if (div_fin) begin
            f_tot <= div_q;
            if (renorm_take) begin
              div_num <= total;
              div_den <= cp_r;
              div_go  <= 1'b1;
              state   <= ST_RC;
            end else begin
              state <= ST_PACK;
            end
          end
        end
        ST_RC: begin
          if (div_fin) begin
            c_tot   <= div_q;
            div_num <= div_r;
            div_den <= fp_r;
            div_go  <= 1'b1;
            state   <= ST_RF;
          end
        end
        ST_RF: begin
          if (div_fin) begin
            f_tot <= div_q;
            state <= ST_PACK;
          end
        end
        ST_PACK: begin
          cfg_word   <= pack_word;
          ovf_coarse <= pack_ovf_c;
          ovf_fine   <= pack_ovf_f;
          done       <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dly_elem_encoder.sv
module dly_elem_encoder
  import dly_enc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] req_word,
  input  logic [DW-1:0]     coarse_param,
  input  logic [DW-1:0]     fine_param,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] cfg_word,
  output logic              ovf_coarse,
  output logic              ovf_fine
);

  logic              div_go;
  logic              div_fin;
  logic [DW-1:0]     div_num;
  logic [DW-1:0]     div_den;
  logic [DW-1:0]     div_q;
  logic [DW-1:0]     div_r;
  logic [DW-1:0]     c_tot;
  logic [DW-1:0]     f_tot;
  logic [WORD_W-1:0] pack_word;
  logic              pack_ovf_c;
  logic              pack_ovf_f;
  logic              renorm_take;

  dly_enc_divider #(.DW(DW)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (div_go),
    .num  (div_num),
    .den  (div_den),
    .fin  (div_fin),
    .quo  (div_q),
    .rem  (div_r)
  );

  dly_enc_pack #(.DW(DW)) u_pack (
    .c_cnt(c_tot),
    .f_cnt(f_tot),
    .word (pack_word),
    .ovf_c(pack_ovf_c),
    .ovf_f(pack_ovf_f)
  );

  dly_enc_ctrl #(.DW(DW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .req_word    (req_word),
    .coarse_param(coarse_param),
    .fine_param  (fine_param),
    .div_fin     (div_fin),
    .div_q       (div_q),
    .div_r       (div_r),
    .div_go      (div_go),
    .div_num     (div_num),
    .div_den     (div_den),
    .c_tot       (c_tot),
    .f_tot       (f_tot),
    .pack_word   (pack_word),
    .pack_ovf_c  (pack_ovf_c),
    .pack_ovf_f  (pack_ovf_f),
    .renorm_take (renorm_take),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .cfg_word    (cfg_word),
    .ovf_coarse  (ovf_coarse),
    .ovf_fine    (ovf_fine)
  );

endmodule

// File: rtl/dly_enc_checker.sv
module dly_enc_checker #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [31:0]   cfg_word,
  input logic [DW-1:0] coarse_param,
  input logic [DW-1:0] fine_param,
  input logic          div_fin
);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_err_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !busy && (cfg_word == 32'h0)));

  p_zero_param_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ((coarse_param == '0) || (fine_param == '0))) |=> (done && err && !busy));

  p_word_layout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ((cfg_word[17:12] == 6'h29) && cfg_word[10] && !cfg_word[11]
                        && (cfg_word[31:18] == 14'h0)));

  p_div_in_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    div_fin |-> busy);

endmodule

bind dly_elem_encoder dly_enc_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .err         (err),
  .cfg_word    (cfg_word),
  .coarse_param(coarse_param),
  .fine_param  (fine_param),
  .div_fin     (div_fin)
);

// File: tb/dly_elem_encoder_bench.sv
`timescale 1ns/1ps
module dly_elem_encoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] req_word = '0;
  logic [31:0] coarse_param = '0;
  logic [31:0] fine_param = '0;
  logic        busy, done, err, ovf_coarse, ovf_fine;
  logic [31:0] cfg_word;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dly_elem_encoder u_dly_elem_encoder (
    .clk(clk), .rst_n(rst_n), .start(start), .req_word(req_word),
    .coarse_param(coarse_param), .fine_param(fine_param),
    .busy(busy), .done(done), .err(err), .cfg_word(cfg_word),
    .ovf_coarse(ovf_coarse), .ovf_fine(ovf_fine)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Independent restatement of R1..R7 in wide integers
  function automatic void expect_word(input int unsigned fixd, input int unsigned cal,
                                      input int unsigned cp, input int unsigned fp,
                                      output logic [31:0] w, output bit oc, output bit of);
    longint unsigned cc;
    longint unsigned ff;
    longint unsigned tot;
    cc = longint'(fixd / 920) + longint'(cal / cp);
    ff = ((((fixd % 920) * 10) / 60) + (((cal % cp) * 10) / fp)) / 10;
    if (ff > 22) begin
      tot = (cc * cp + ff * fp) & 64'hFFFF_FFFF;
      cc  = tot / cp;
      ff  = (tot % cp) / fp;
    end
    oc = (cc > 31);
    of = (ff > 31);
    w  = (32'h29 << 12) | (32'h1 << 10) | (32'(cc & 31) << 5) | 32'(ff & 31);
  endfunction

  task automatic pulse_start(input int unsigned fixd, input int unsigned cal,
                             input int unsigned cp, input int unsigned fp);
    @(negedge clk);
    req_word     = {fixd[15:0], cal[15:0]};
    coarse_param = cp;
    fine_param   = fp;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      if (done) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_case(input string tag, input int unsigned fixd, input int unsigned cal,
                          input int unsigned cp, input int unsigned fp);
    logic [31:0] ew;
    bit eoc, eof, seen;
    expect_word(fixd, cal, cp, fp, ew, eoc, eof);
    pulse_start(fixd, cal, cp, fp);
    chk(busy == 1'b1, {tag, " R9 busy after start"}, busy, 1);
    wait_done(seen);
    chk(seen, {tag, " R9 done seen"}, seen, 1);
    chk(cfg_word == ew, {tag, " R2 R3 R4 R5 R6 word"}, cfg_word, ew);
    chk(ovf_coarse == eoc && ovf_fine == eof, {tag, " R7 flags"},
        {ovf_coarse, ovf_fine}, {eoc, eof});
    chk(err == 1'b0, {tag, " R8 no err"}, err, 0);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, {tag, " R9 single pulse"}, {done, busy}, 0);
  endtask

  task automatic test_reset();
    chk(busy == 0 && done == 0 && err == 0, "R11 reset ctl", {busy, done, err}, 0);
    chk(cfg_word == 0 && ovf_coarse == 0 && ovf_fine == 0, "R11 reset data", cfg_word, 0);
  endtask

  task automatic test_layout_r1();
    // fixed part 1840 ps -> 2 coarse, calibrated part 0: word 0x29440
    run_case("R1 fixed only", 1840, 0, 1000, 100);
    chk(cfg_word == 32'h0002_9440, "R1 R6 literal word", cfg_word, 32'h0002_9440);
  endtask

  task automatic test_mixed();
    run_case("R3 mixed a", 1000, 2500, 300, 45);
    run_case("R2 mixed b", 919, 777, 91, 33);
    run_case("R4 mixed c", 5555, 12345, 250, 40);
  endtask

  task automatic test_renorm_r5();
    // fine count exactly 22: kept, word fine=22 coarse=0
    run_case("R5 at 22", 919, 53, 100, 7);
    chk(cfg_word[9:0] == 10'd22, "R5 no renorm at 22", cfg_word[9:0], 22);
    // fine count 23: renormalised to coarse 1 fine 8
    run_case("R5 at 23", 919, 54, 100, 7);
    chk(cfg_word[9:0] == {5'd1, 5'd8}, "R5 renorm at 23", cfg_word[9:0], {5'd1, 5'd8});
  endtask

  task automatic test_overflow_r7();
    run_case("R7 coarse ovf", 65535, 0, 1000, 100);
    chk(ovf_coarse == 1'b1 && cfg_word[9:5] == 5'd7, "R7 coarse trunc", cfg_word[9:5], 7);
    run_case("R7 fine ovf", 0, 999, 1000, 10);
    chk(ovf_fine == 1'b1 && cfg_word[4:0] == 5'd3, "R7 fine trunc", cfg_word[4:0], 3);
  endtask

  task automatic test_zero_r8(input int unsigned cp, input int unsigned fp);
    pulse_start(100, 100, cp, fp);
    chk(done == 1 && err == 1 && busy == 0, "R8 zero param flags", {done, err, busy}, 3'b110);
    chk(cfg_word == 0 && ovf_coarse == 0 && ovf_fine == 0, "R8 zero param word", cfg_word, 0);
    @(negedge clk);
    chk(done == 0 && err == 0, "R8 R9 err pulse ends", {done, err}, 0);
  endtask

  task automatic test_busy_ignore_r10();
    logic [31:0] ew;
    bit eoc, eof, seen;
    int extra;
    expect_word(3000, 4000, 200, 30, ew, eoc, eof);
    pulse_start(3000, 4000, 200, 30);
    repeat (5) @(negedge clk);
    req_word = {16'd60000, 16'd60000}; coarse_param = 7; fine_param = 3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    req_word = {16'd3000, 16'd4000}; coarse_param = 200; fine_param = 30;
    wait_done(seen);
    chk(seen && cfg_word == ew, "R10 first result kept", cfg_word, ew);
    extra = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R10 no extra done", extra, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_layout_r1();
    test_mixed();
    test_renorm_r5();
    test_overflow_r7();
    test_zero_r8(0, 50);
    test_zero_r8(400, 0);
    test_busy_ignore_r10();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule